// File: doc/BRIEF.md
# Dual/Single Mode Line Decoder with Output Polarity Select

This block is a purely combinational address decoder with two ways of working, chosen by one mode input. With the mode input LOW it acts as two separate 2-to-4 decoders. The lower half turns a two-bit address into one of output lines 0 to 3, and the upper half turns its own two-bit address into one of lines 4 to 7. With the mode input HIGH it acts as one 3-to-8 decoder. In that mode the lower-half address plus one extra most-significant bit picks one of all eight lines.

Each half has two active-low enables. In single mode all four enables must be LOW for any line to be asserted. Output polarity is set per half: the half's own select ORed with a common select. HIGH gives active-high lines (the chosen line HIGH and the rest LOW). LOW gives the complement. The block has no clock and no reset. A designer uses it to fan one address out to chip selects, or two smaller addresses to two separate groups of four selects.

Top module: `dmx_mode_decoder`

## Requirements
- R1: In dual mode (mode_sel = 0), with both lower enables LOW and effective lower polarity HIGH, dec_out[addr_lo] is HIGH and the other lines of dec_out[3:0] are LOW.
- R2: In dual mode, with both upper enables LOW and effective upper polarity HIGH, dec_out[4 + addr_hi] is HIGH and the other lines of dec_out[7:4] are LOW.
- R3: In dual mode, addr_msb has no effect on any output line.
- R4: In dual mode, if either enable of a half is HIGH, all four lines of that half are at their inactive level.
- R5: In single mode (mode_sel = 1), with all four enables LOW and effective polarity HIGH, dec_out[{addr_msb, addr_lo}] is HIGH (addr_msb is the MSB of the index) and all other lines are LOW.
- R6: In single mode, if any of the four enables is HIGH, all eight lines are at their inactive level.
- R7: In single mode, addr_hi has no effect on any output line.
- R8: The effective polarity of lines 0-3 is pol_lo OR pol_all, and of lines 4-7 is pol_hi OR pol_all. When it is LOW, every line of that half is the complement of its active-high value.
- R9: In dual mode the two halves are independent: enables and address of one half do not change the other half's lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_sel | input | 1 | 0 = two 2-to-4 decoders, 1 = one 3-to-8 decoder |
| addr_lo | input | 2 | Lower-half address; low two index bits in single mode |
| addr_msb | input | 1 | Index MSB, used only in single mode |
| addr_hi | input | 2 | Upper-half address, used only in dual mode |
| en_lo_n | input | 2 | Lower-half active-low enables |
| en_hi_n | input | 2 | Upper-half active-low enables |
| pol_lo | input | 1 | Polarity select for lines 0-3 |
| pol_hi | input | 1 | Polarity select for lines 4-7 |
| pol_all | input | 1 | Common polarity select, ORed into both halves |
| dec_out | output | 8 | Decoded lines |

## Verification
The bench sweeps all 8192 input combinations, so it reaches every corner case. The key ones are a stray addr_msb in dual mode, which a faulty design would let shift the selection into the upper half, and nonzero upper-half address bits in single mode, which a faulty design would let assert a second line. It also covers a single HIGH enable on the other half in single mode: a faulty design would leave half of the lines live. With the polarity selects crossed, a faulty design would complement the wrong half or fail to complement at all. Each half is compared on its own, so a failure that leaks from one half into the other is reported against the half it damaged.

// File: rtl/dmx_pkg.sv
// Shared sizing for the mode decoder. Assumes two halves of equal width.
package dmx_pkg;
    localparam int unsigned HALF_AW  = 2;
    localparam int unsigned EN_COUNT = 2;
endpackage

// File: rtl/dmx_enable_gate.sv
// Turns the active-low enable pins into one activity flag per half.
// Assumes that in single mode both flags must mean "all enables LOW".
module dmx_enable_gate #(
    parameter int unsigned EN_N = dmx_pkg::EN_COUNT
) (
    input  logic            mode_sel,
    input  logic [EN_N-1:0] en_lo_n,
    input  logic [EN_N-1:0] en_hi_n,
    output logic            act_lo,
    output logic            act_hi
);
    logic lo_ok, hi_ok;

    // Per-half qualification and mode-dependent combination.
    always_comb begin
        lo_ok  = ~|en_lo_n;
        hi_ok  = ~|en_hi_n;
        act_lo = mode_sel ? (lo_ok & hi_ok) : lo_ok;
        act_hi = mode_sel ? (lo_ok & hi_ok) : hi_ok;
    end
endmodule

// File: rtl/dmx_onehot.sv
// Binary to one-hot decoder with an enable. Output is all zero when disabled.
module dmx_onehot #(
    parameter int unsigned AW = dmx_pkg::HALF_AW,
    localparam int unsigned N = 1 << AW
) (
    input  logic [AW-1:0] sel,
    input  logic          enable,
    output logic [N-1:0]  hot
);
    // Sets exactly one bit when enabled.
    always_comb begin
        hot = '0;
        if (enable) hot[sel] = 1'b1;
    end

    // Enabled decoding yields one bit, disabled yields none.
    always_comb begin
        a_r5_onehot_count: assert ($countones(hot) == (enable ? 1 : 0))
            else $error("onehot count wrong");
    end
endmodule

// File: rtl/dmx_polarity.sv
// Applies the effective polarity of one half: own select ORed with the common one.
module dmx_polarity #(
    parameter int unsigned N = 1 << dmx_pkg::HALF_AW
) (
    input  logic [N-1:0] hot,
    input  logic         pol_half,
    input  logic         pol_common,
    output logic [N-1:0] line
);
    logic active_high;

    // Pass or complement the one-hot pattern.
    always_comb begin
        active_high = pol_half | pol_common;
        line        = active_high ? hot : ~hot;
    end

    // Active-low output never has more than one LOW line.
    always_comb begin
        if (!pol_half && !pol_common)
            a_r8_low_polarity: assert ($countones(line) >= N - 1)
                else $error("inverted half has too many LOW lines");
    end
endmodule

// File: rtl/dmx_mode_decoder.sv
// Top: two 2-to-4 decoders or one 3-to-8 decoder, picked by mode_sel,
// with per-half output polarity. Purely combinational; no clock or reset.
module dmx_mode_decoder #(
    parameter int unsigned HAW  = dmx_pkg::HALF_AW,
    parameter int unsigned EN_N = dmx_pkg::EN_COUNT,
    localparam int unsigned HN  = 1 << HAW,
    localparam int unsigned FAW = HAW + 1,
    localparam int unsigned FN  = 2 * HN
) (
    input  logic            mode_sel,
    input  logic [HAW-1:0]  addr_lo,
    input  logic            addr_msb,
    input  logic [HAW-1:0]  addr_hi,
    input  logic [EN_N-1:0] en_lo_n,
    input  logic [EN_N-1:0] en_hi_n,
    input  logic            pol_lo,
    input  logic            pol_hi,
    input  logic            pol_all,
    output logic [FN-1:0]   dec_out
);
    logic          act_lo, act_hi;
    logic [HN-1:0] hot_lo, hot_hi;
    logic [FN-1:0] hot_all, hot_sel;
    logic [1:0]    pol_half;

    dmx_enable_gate #(.EN_N(EN_N)) u_gate (
        .mode_sel(mode_sel), .en_lo_n(en_lo_n), .en_hi_n(en_hi_n),
        .act_lo(act_lo), .act_hi(act_hi)
    );

    dmx_onehot #(.AW(HAW)) u_dec_lo (.sel(addr_lo), .enable(act_lo), .hot(hot_lo));
    dmx_onehot #(.AW(HAW)) u_dec_hi (.sel(addr_hi), .enable(act_hi), .hot(hot_hi));
    dmx_onehot #(.AW(FAW)) u_dec_all (.sel({addr_msb, addr_lo}), .enable(act_lo), .hot(hot_all));

    // Chooses between the split and the full-width decode.
    always_comb begin
        hot_sel     = mode_sel ? hot_all : {hot_hi, hot_lo};
        pol_half[0] = pol_lo;
        pol_half[1] = pol_hi;
    end

    for (genvar g = 0; g < 2; g++) begin : g_half
        dmx_polarity #(.N(HN)) u_pol (
            .hot(hot_sel[g*HN +: HN]), .pol_half(pol_half[g]),
            .pol_common(pol_all), .line(dec_out[g*HN +: HN])
        );
    end

    // Mode and enable behaviour seen at the decode stage.
    always_comb begin
        if (mode_sel && ((|en_lo_n) || (|en_hi_n)))
            a_r6_single_idle: assert (hot_sel == '0) else $error("single mode not idle");
        if (mode_sel && !(|en_lo_n) && !(|en_hi_n))
            a_r5_single_pick: assert (hot_sel[{addr_msb, addr_lo}]) else $error("single pick");
        if (!mode_sel && !(|en_lo_n))
            a_r1_lower_pick: assert (hot_sel[addr_lo]) else $error("lower pick");
        if (!mode_sel && (|en_lo_n))
            a_r4_lower_idle: assert (hot_sel[HN-1:0] == '0) else $error("lower idle");
        if (!mode_sel && !(|en_hi_n))
            a_r2_upper_pick: assert (hot_sel[HN + addr_hi]) else $error("upper pick");
    end
endmodule

// File: tb/test_dmx_mode_decoder.sv
module test_dmx_mode_decoder;
    logic       clk = 1'b0;
    logic       mode_sel, addr_msb, pol_lo, pol_hi, pol_all;
    logic [1:0] addr_lo, addr_hi, en_lo_n, en_hi_n;
    logic [7:0] dec_out;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    dmx_mode_decoder i_dmx_mode_decoder (
        .mode_sel(mode_sel), .addr_lo(addr_lo), .addr_msb(addr_msb),
        .addr_hi(addr_hi), .en_lo_n(en_lo_n), .en_hi_n(en_hi_n),
        .pol_lo(pol_lo), .pol_hi(pol_hi), .pol_all(pol_all), .dec_out(dec_out)
    );

    task automatic check_half(input string tag, input int h,
                              input logic [3:0] act, input logic [3:0] exp, input int v);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s vector=%0d half=%0d actual=%b expected=%b", tag, v, h, act, exp);
        end
    endtask

    initial begin
        {mode_sel, addr_msb, pol_lo, pol_hi, pol_all, addr_lo, addr_hi, en_lo_n, en_hi_n} = '0;
        for (int v = 0; v < 8192; v++) begin
            logic [7:0] hot, exp;
            logic       en_all, ok_lo, ok_hi;
            logic [1:0] peff;
            @(posedge clk);
            mode_sel = v[0];  addr_lo = v[2:1]; addr_msb = v[3]; addr_hi = v[5:4];
            en_lo_n  = v[7:6]; en_hi_n = v[9:8]; pol_lo = v[10]; pol_hi = v[11];
            pol_all  = v[12];
            ok_lo  = (v[7:6] == 2'b00);
            ok_hi  = (v[9:8] == 2'b00);
            en_all = ok_lo && ok_hi;
            hot    = '0;
            if (v[0]) begin
                if (en_all) hot = 8'(1 << (v[3] * 4 + v[2:1]));
            end else begin
                if (ok_lo) hot[3:0] = 4'(1 << v[2:1]);
                if (ok_hi) hot[7:4] = 4'(1 << v[5:4]);
            end
            peff[0] = v[10] | v[12];
            peff[1] = v[11] | v[12];
            exp[3:0] = peff[0] ? hot[3:0] : ~hot[3:0];
            exp[7:4] = peff[1] ? hot[7:4] : ~hot[7:4];
            @(negedge clk);
            for (int h = 0; h < 2; h++) begin
                string tag;
                logic  mine, other;
                mine  = (h == 0) ? ok_lo : ok_hi;
                other = (h == 0) ? ok_hi : ok_lo;
                if (!peff[h])                      tag = "R8";
                else if (v[0] && !en_all)          tag = "R6";
                else if (v[0] && v[5:4] != 2'b00)  tag = "R7";
                else if (v[0])                     tag = "R5";
                else if (!mine)                    tag = "R4";
                else if (!other)                   tag = "R9";
                else if (h == 0 && v[3])           tag = "R3";
                else                               tag = (h == 0) ? "R1" : "R2";
                check_half(tag, h, dec_out[h*4 +: 4], exp[h*4 +: 4], v);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (R1 sweep) actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule